// File: doc/BRIEF.md
# Atomic 64-byte load sequencer

This block carries out one atomic 64-byte load. A one-cycle `start` pulse captures a destination register number, a base register number, the stack pointer value and the big-endian flag. In the next cycle the block checks the encoding and reads the base register through a read port. It then either reports a fault or issues one 512-bit read request to memory.

When the memory response arrives, the 512-bit line is cut into eight 64-bit doublewords. Each doubleword is byte-reversed when big-endian mode was set at start. The block then writes them, one per cycle in ascending order, into eight consecutive registers through a register-file write port.

States: `ST_IDLE` waits for `start`; `ST_CHECK` decodes and either faults (back to `ST_IDLE`) or moves to `ST_REQ`; `ST_REQ` holds the request until `mem_req_ready`, then goes to `ST_WAIT`; `ST_WAIT` waits for `mem_rsp_valid` and then goes to `ST_WRITE`; `ST_WRITE` emits eight writes and returns to `ST_IDLE` on the last one.

Top module: `ld64_seq`

## Requirements
- R1: After reset, `busy`, `fault`, `done`, `mem_req_valid` and `rf_we` are all 0.
- R2: If `feat_en` is 0 at start, the block pulses `fault` with cause 0, whatever the other fields hold.
- R3: A destination field with bits [4:3] equal to 2'b11, or with bit 0 set, gives a fault with cause 1. Feature-disabled (cause 0) takes priority over it.
- R4: A base field of 31 selects the stack pointer. If the low four bits of the stack pointer are not zero, the fault cause is 2. Any other base value is driven on `rf_rd_idx` during the check cycle, and `rf_rd_data` is used as the address.
- R5: An effective address whose low six bits are not zero gives cause 3. This cause has the lowest priority. When no fault applies, `fault` stays 0.
- R6: `fault` is a single-cycle pulse in the cycle after `start`. No memory request is issued for a faulting instruction, and `busy` falls in the following cycle.
- R7: `mem_req_valid` rises two cycles after `start`. It stays high with a stable, 64-byte-aligned `mem_req_addr` until `mem_req_ready` is seen. `mem_req_tagchk` is 1 exactly when the base field is not 31.
- R8: Starting in the cycle after `mem_rsp_valid`, doubleword i (response bits [64i+63:64i]) is written to register t+i. The writes go out for i = 0..7, one per cycle, with no gaps.
- R9: When `big_endian` was 1 at start, the eight bytes of each doubleword are reversed before writing. Otherwise they pass through unchanged.
- R10: `busy` is high from the cycle after `start` through the last write. `done` is high only together with the eighth write.
- R11: A `start` pulse while `busy` is high is ignored. The instruction in flight completes with its original fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one load (sampled while idle) |
| feat_en | input | 1 | Feature enable |
| big_endian | input | 1 | Byte-reverse each doubleword |
| dst_field | input | 5 | First destination register number |
| base_field | input | 5 | Base register number, 31 = stack pointer |
| sp_val | input | 64 | Stack pointer value |
| rf_rd_idx | output | 5 | Base register read index |
| rf_rd_data | input | 64 | Base register read data |
| fault | output | 1 | One-cycle fault pulse |
| fault_cause | output | 2 | Fault code (0..3) |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Request byte address |
| mem_req_tagchk | output | 1 | Tag-checked flag |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_data | input | 512 | Response line |
| rf_we | output | 1 | Register write enable |
| rf_widx | output | 5 | Register write index |
| rf_wdata | output | 64 | Register write data |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | Last write of the sequence |

## Verification
The bench builds the block with its default parameters: 64-bit doublewords, eight of them per line, 5-bit register numbers, 64-byte line alignment and 16-byte stack alignment. With these values the full register-legality rule is exercised, including the highest legal start register, 22. The fault priority order is reached by combining several faults in one encoding. The swap is tested on every byte lane of all eight doublewords. Random ready and response delays exercise holding the request and ignoring a stray start while the load is in flight.

// File: rtl/ld64_pkg.sv
package ld64_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_REQ   = 3'd2,
        ST_WAIT  = 3'd3,
        ST_WRITE = 3'd4
    } ld_state_e;

    typedef enum logic [1:0] {
        FC_FEAT = 2'd0,
        FC_REG  = 2'd1,
        FC_SPAL = 2'd2,
        FC_ADDR = 2'd3
    } fault_cause_e;
endpackage

// File: rtl/ld64_decode.sv
module ld64_decode
    import ld64_pkg::*;
#(
    parameter int AW         = 64,
    parameter int RIW        = 5,
    parameter int LINE_BYTES = 64,
    parameter int SP_ALIGN   = 16
) (
    input  logic           feat_en,
    input  logic [RIW-1:0] dst,
    input  logic [RIW-1:0] base,
    input  logic [AW-1:0]  sp_val,
    input  logic [AW-1:0]  gpr_val,
    output logic [AW-1:0]  eff_addr,
    output logic           tagchk,
    output logic           flt,
    output fault_cause_e   cause
);
    localparam int LINE_LSB = $clog2(LINE_BYTES);
    localparam int SP_LSB   = $clog2(SP_ALIGN);

    logic use_sp, reg_bad, sp_mis, addr_mis;

    always_comb begin
        use_sp   = (base == {RIW{1'b1}});
        reg_bad  = (dst[RIW-1:RIW-2] == 2'b11) || dst[0];
        eff_addr = use_sp ? sp_val : gpr_val;
        sp_mis   = use_sp && (|sp_val[SP_LSB-1:0]);
        addr_mis = |eff_addr[LINE_LSB-1:0];
        tagchk   = !use_sp;
        flt      = 1'b1;
        cause    = FC_ADDR;
        if (!feat_en)      cause = FC_FEAT;
        else if (reg_bad)  cause = FC_REG;
        else if (sp_mis)   cause = FC_SPAL;
        else if (addr_mis) cause = FC_ADDR;
        else               flt   = 1'b0;
    end
endmodule

// File: rtl/ld64_bswap.sv
module ld64_bswap #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] din,
    input  logic          rev,
    output logic [DW-1:0] dout
);
    localparam int NB = DW / 8;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign dout[8*b +: 8] = rev ? din[8*(NB-1-b) +: 8] : din[8*b +: 8];
    end
endmodule

// File: rtl/ld64_wrseq.sv
module ld64_wrseq #(
    parameter int NW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  step,
    output logic [$clog2(NW)-1:0] idx,
    output logic                  last
);
    localparam int CW = $clog2(NW);
    localparam logic [CW-1:0] LAST_IDX = CW'(NW - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     idx <= '0;
        else if (clear) idx <= '0;
        else if (step)  idx <= idx + 1'b1;
    end

    assign last = (idx == LAST_IDX);
endmodule

// File: rtl/ld64_seq.sv
module ld64_seq
    import ld64_pkg::*;
#(
    parameter int AW         = 64,
    parameter int DW         = 64,
    parameter int NW         = 8,
    parameter int RIW        = 5,
    parameter int LINE_BYTES = 64,
    parameter int SP_ALIGN   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             feat_en,
    input  logic             big_endian,
    input  logic [RIW-1:0]   dst_field,
    input  logic [RIW-1:0]   base_field,
    input  logic [AW-1:0]    sp_val,
    output logic [RIW-1:0]   rf_rd_idx,
    input  logic [AW-1:0]    rf_rd_data,
    output logic             fault,
    output logic [1:0]       fault_cause,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [AW-1:0]    mem_req_addr,
    output logic             mem_req_tagchk,
    input  logic             mem_rsp_valid,
    input  logic [NW*DW-1:0] mem_rsp_data,
    output logic             rf_we,
    output logic [RIW-1:0]   rf_widx,
    output logic [DW-1:0]    rf_wdata,
    output logic             busy,
    output logic             done
);
    localparam int LW = NW * DW;
    localparam int CW = $clog2(NW);

    ld_state_e      state, state_nx;
    logic [RIW-1:0] dst_q, base_q;
    logic [AW-1:0]  sp_q, addr_q;
    logic           be_q, tag_q;
    logic [LW-1:0]  line_q;

    logic [AW-1:0]  dec_addr;
    logic           dec_tag, dec_flt;
    fault_cause_e   dec_cause;
    logic [CW-1:0]  wcnt;
    logic           wlast;
    logic [DW-1:0]  raw_word;

    ld64_decode #(
        .AW(AW), .RIW(RIW), .LINE_BYTES(LINE_BYTES), .SP_ALIGN(SP_ALIGN)
    ) u_dec (
        .feat_en (feat_q),
        .dst     (dst_q),
        .base    (base_q),
        .sp_val  (sp_q),
        .gpr_val (rf_rd_data),
        .eff_addr(dec_addr),
        .tagchk  (dec_tag),
        .flt     (dec_flt),
        .cause   (dec_cause)
    );

    ld64_wrseq #(.NW(NW)) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(state != ST_WRITE),
        .step (state == ST_WRITE),
        .idx  (wcnt),
        .last (wlast)
    );

    assign raw_word = line_q[wcnt*DW +: DW];

    ld64_bswap #(.DW(DW)) u_swap (
        .din (raw_word),
        .rev (be_q),
        .dout(rf_wdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)         state_nx = ST_CHECK;
            ST_CHECK: state_nx = dec_flt ? ST_IDLE : ST_REQ;
            ST_REQ:   if (mem_req_ready) state_nx = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_nx = ST_WRITE;
            ST_WRITE: if (wlast)         state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // captured operands and line
    logic feat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            feat_q <= 1'b0;
            be_q   <= 1'b0;
            dst_q  <= '0;
            base_q <= '0;
            sp_q   <= '0;
            addr_q <= '0;
            tag_q  <= 1'b0;
            line_q <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                feat_q <= feat_en;
                be_q   <= big_endian;
                dst_q  <= dst_field;
                base_q <= base_field;
                sp_q   <= sp_val;
            end
            if (state == ST_CHECK) begin
                addr_q <= dec_addr;
                tag_q  <= dec_tag;
            end
            if (state == ST_WAIT && mem_rsp_valid) line_q <= mem_rsp_data;
        end
    end

    // outputs
    always_comb begin
        busy           = (state != ST_IDLE);
        rf_rd_idx      = base_q;
        fault          = (state == ST_CHECK) && dec_flt;
        fault_cause    = dec_cause;
        mem_req_valid  = (state == ST_REQ);
        mem_req_addr   = addr_q;
        mem_req_tagchk = tag_q;
        rf_we          = (state == ST_WRITE);
        rf_widx        = dst_q + RIW'(wcnt);
        done           = (state == ST_WRITE) && wlast;
    end
endmodule

// File: rtl/ld64_seq_chk.sv
module ld64_seq_chk #(
    parameter int AW         = 64,
    parameter int RIW        = 5,
    parameter int LINE_BYTES = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic           fault,
    input logic           busy,
    input logic           done,
    input logic           mem_req_valid,
    input logic           mem_req_ready,
    input logic [AW-1:0]  mem_req_addr,
    input logic           rf_we,
    input logic [RIW-1:0] rf_widx
);
    localparam int LINE_LSB = $clog2(LINE_BYTES);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    // R7
    req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[LINE_LSB-1:0] == '0));
    // R6
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault && !busy);
    // R6
    fault_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !mem_req_valid && !rf_we);
    // R8
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we && !done |=> rf_we && (rf_widx == $past(rf_widx) + 1'b1));
    // R10
    done_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rf_we && busy);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind ld64_seq ld64_seq_chk #(.AW(AW), .RIW(RIW), .LINE_BYTES(LINE_BYTES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault        (fault),
    .busy         (busy),
    .done         (done),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .rf_we        (rf_we),
    .rf_widx      (rf_widx)
);

// File: tb/sim_ld64_seq.sv
`timescale 1ns/1ps
module sim_ld64_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0, feat_en = 1'b0, big_endian = 1'b0;
    logic [4:0]   dst_field = '0, base_field = '0;
    logic [63:0]  sp_val = '0, rf_rd_data = '0;
    logic         mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [511:0] mem_rsp_data = '0;
    logic [4:0]   rf_rd_idx, rf_widx;
    logic         fault, mem_req_valid, mem_req_tagchk, rf_we, busy, done;
    logic [1:0]   fault_cause;
    logic [63:0]  mem_req_addr, rf_wdata;

    int n_chk = 0, n_bad = 0, cyc = 0;

    always #2 clk = ~clk;

    ld64_seq u0 (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] bswap(input logic [63:0] v);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
        return r;
    endfunction

    function automatic int exp_fault(input bit fe, input logic [4:0] rt, input logic [4:0] rn,
                                     input logic [63:0] sp, input logic [63:0] gpr);
        logic [63:0] a;
        if (!fe) return 0;
        if (rt[4:3] == 2'b11 || rt[0]) return 1;
        if (rn == 5'd31 && sp[3:0] != 4'h0) return 2;
        a = (rn == 5'd31) ? sp : gpr;
        if (a[5:0] != 6'h0) return 3;
        return -1;
    endfunction

    task automatic run(input bit fe, input logic [4:0] rt, input logic [4:0] rn,
                       input logic [63:0] sp, input logic [63:0] gpr, input bit be,
                       input int rdy_dly, input int rsp_dly, input bit intrude);
        int ef;
        logic [511:0] line;
        logic [63:0] ea, w;
        ef = exp_fault(fe, rt, rn, sp, gpr);
        ea = (rn == 5'd31) ? sp : gpr;
        for (int k = 0; k < 16; k++) line[32*k +: 32] = $urandom;
        @(negedge clk);
        feat_en = fe; dst_field = rt; base_field = rn; sp_val = sp;
        rf_rd_data = gpr; big_endian = be; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10 busy after start", 64'(busy), 64'd1);
        if (rn != 5'd31) check(rf_rd_idx == rn, "R4 read index", 64'(rf_rd_idx), 64'(rn));
        if (ef >= 0) begin
            check(fault == 1'b1 && fault_cause == 2'(ef),
                  ef == 0 ? "R2 cause" : ef == 1 ? "R3 cause" : ef == 2 ? "R4 cause" : "R5 cause",
                  {62'd0, fault_cause}, 64'(ef));
            check(mem_req_valid == 1'b0, "R6 no request", 64'(mem_req_valid), 64'd0);
            @(negedge clk);
            check(fault == 1'b0 && busy == 1'b0 && mem_req_valid == 1'b0, "R6 pulse end",
                  {61'd0, fault, busy, mem_req_valid}, 64'd0);
            return;
        end
        check(fault == 1'b0, "R5 no fault", 64'(fault), 64'd0);
        @(negedge clk);
        check(mem_req_valid == 1'b1 && mem_req_addr == ea, "R7 request addr", mem_req_addr, ea);
        check(mem_req_tagchk == (rn != 5'd31), "R7 tagchk", 64'(mem_req_tagchk), 64'(rn != 5'd31));
        for (int d = 0; d < rdy_dly; d++) begin
            @(negedge clk);
            check(mem_req_valid == 1'b1 && mem_req_addr == ea, "R7 hold", mem_req_addr, ea);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check(mem_req_valid == 1'b0, "R7 accepted", 64'(mem_req_valid), 64'd0);
        if (intrude) begin
            dst_field = 5'd2; base_field = 5'd31; big_endian = ~be; feat_en = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(fault == 1'b0 && mem_req_valid == 1'b0, "R11 start ignored",
                  {62'd0, fault, mem_req_valid}, 64'd0);
        end
        for (int d = 0; d < rsp_dly; d++) begin
            @(negedge clk);
            check(rf_we == 1'b0, "R8 no early write", 64'(rf_we), 64'd0);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = line;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = ~line;
        for (int i = 0; i < 8; i++) begin
            w = be ? bswap(line[64*i +: 64]) : line[64*i +: 64];
            check(rf_we == 1'b1 && rf_widx == rt + 5'(i), "R8 write index", 64'(rf_widx), 64'(rt + 5'(i)));
            check(rf_wdata == w, be ? "R9 swapped data" : "R8 data", rf_wdata, w);
            check(done == (i == 7), "R10 done", 64'(done), 64'(i == 7));
            @(negedge clk);
        end
        check(busy == 1'b0 && rf_we == 1'b0, "R10 idle after", {62'd0, busy, rf_we}, 64'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] rt, rn;
        logic [63:0] sp, gp;
        void'($urandom(32'd7391));
        repeat (3) @(negedge clk);
        // R1 reset state
        check({busy, fault, done, mem_req_valid, rf_we} == 5'd0, "R1 reset",
              {59'd0, busy, fault, done, mem_req_valid, rf_we}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, fault, done, mem_req_valid, rf_we} == 5'd0, "R1 after release",
              {59'd0, busy, fault, done, mem_req_valid, rf_we}, 64'd0);
        // directed corners
        run(1'b0, 5'd24, 5'd3, 64'h0, 64'h41, 1'b0, 0, 0, 1'b0);      // R2 over R3
        run(1'b1, 5'd24, 5'd3, 64'h0, 64'h1000, 1'b0, 0, 0, 1'b0);    // R3 bits 4:3
        run(1'b1, 5'd1, 5'd3, 64'h0, 64'h1001, 1'b0, 0, 0, 1'b0);     // R3 over R5
        run(1'b1, 5'd4, 5'd31, 64'h2008, 64'h0, 1'b0, 0, 0, 1'b0);    // R4 SP misaligned
        run(1'b1, 5'd4, 5'd31, 64'h2010, 64'h0, 1'b0, 0, 0, 1'b0);    // R5 SP ok, line not
        run(1'b1, 5'd6, 5'd7, 64'h8, 64'h3020, 1'b0, 0, 0, 1'b0);     // R5 gpr misaligned
        run(1'b1, 5'd22, 5'd31, 64'hFFC0, 64'h0, 1'b1, 2, 1, 1'b0);   // R8 R9 top register
        run(1'b1, 5'd0, 5'd30, 64'h4, 64'hABC0, 1'b0, 0, 3, 1'b1);    // R11 R7
        run(1'b1, 5'd16, 5'd0, 64'h0, 64'h0, 1'b1, 4, 0, 1'b1);
        // random mix
        for (int n = 0; n < 80; n++) begin
            rt = ($urandom % 10 < 7) ? 5'(2 * ($urandom % 12)) : 5'($urandom);
            rn = ($urandom % 4 == 0) ? 5'd31 : 5'($urandom % 31);
            sp = {$urandom, $urandom};
            gp = {$urandom, $urandom};
            if ($urandom % 4 != 0) begin sp[5:0] = 6'h0; gp[5:0] = 6'h0; end
            run($urandom % 12 != 0, rt, rn, sp, gp, 1'($urandom), $urandom % 4,
                $urandom % 4, 1'($urandom));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule